// File: doc/BRIEF.md
# DMA Address Stepper

This block holds the running source or destination address of one DMA channel side. A channel uses two copies, one for the reads and one for the writes. The sequencer loads a start address with a single-cycle `load` pulse. After each completed datum it raises `advance` for one cycle, and the stepper then computes the next address. The next address depends on the chosen step rule: hold, count up, count down, or add a signed offset. The up and down steps equal the datum width in bytes.

An optional wrap window can be set on the address. It is a power-of-two region of 2^N bytes, where N comes from a 5-bit code. Inside the window only the low N address bits move, and the upper bits keep their value. When a step carries out of the window and the side's overflow enable is set, the stepper raises a stop request. In single-datum operation the request appears at once. In block operation it is held back until the last datum of the current block has stepped. The stepper keeps stepping while the request is set, so a write that pairs with a read still completes. The sequencer clears the request with `ovf_ack` or with a fresh `load`.

Top module: `dma_addr_step`

## Requirements
- R1: After reset, `addr` is 0 and `ovf_stop` is 0.
- R2: A `load` pulse sets `addr` to `start_addr` in the next cycle. It also clears `ovf_stop` and any held-back overflow, and it takes priority over `advance`.
- R3: With `step_mode` 00 (hold), an advance leaves `addr` unchanged. Without `advance` or `load`, `addr` never changes.
- R4: With `step_mode` 01 (up), each advance adds the datum width in bytes. `size_code` 00 gives 1, 01 gives 2, and 10 or 11 give 4.
- R5: With `step_mode` 10 (down), each advance subtracts the datum width in bytes, using the same size encoding as R4.
- R6: With `step_mode` 11 (offset), each advance adds `offset` as an OFW-bit two's-complement value sign-extended to the address width. A negative value therefore steps down.
- R7: When the parameter OFFSET_EN is 0, `step_mode` 11 behaves like hold.
- R8: An `area_code` N in the range 1 to AW-1 keeps all address bits from N upward unchanged on an advance, so the low N bits wrap modulo 2^N. Code 0 applies no window, and a carry then reaches the upper bits.
- R9: If an advance wraps the window while `ovf_en` is 1 and `block_mode` is 0, `ovf_stop` is 1 from the next cycle on. Later advances still step the address.
- R10: A wrap with `ovf_en` 0 never raises `ovf_stop`.
- R11: With `block_mode` 1, an overflow is held back. `ovf_stop` rises only after the advance that has `block_last` 1, whether that advance is the wrapping one or a later one.
- R12: An `ovf_ack` pulse clears `ovf_stop`. A stop raised by an advance in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Restore the start address and clear overflow state |
| start_addr | input | AW | Start address |
| step_mode | input | 2 | 00 hold, 01 up, 10 down, 11 offset |
| size_code | input | 2 | Datum width: 00 byte, 01 halfword, 1x word |
| offset | input | OFW | Signed step for offset mode |
| area_code | input | 5 | Wrap window size code N (window of 2^N bytes), 0 = no window |
| ovf_en | input | 1 | Allow a window overflow to request a stop |
| block_mode | input | 1 | Hold back the stop until the end of the block |
| block_last | input | 1 | Qualifies an advance as the last datum of a block |
| advance | input | 1 | One datum completed; step the address |
| ovf_ack | input | 1 | Clear the stop request |
| addr | output | AW | Current address |
| ovf_stop | output | 1 | Stop request after a window overflow |

## Verification
The bench builds the main instance with AW=32 and OFW=24. This makes the offset sign extension visible: a 24-bit negative offset must subtract across the upper byte of the address. A second instance with OFFSET_EN=0 shares the same stimulus and shows that offset mode falls back to hold. A 3-bit window (8 bytes) is used to reach wraps in both directions. It also covers the difference between immediate and held-back stop requests, and the clear paths.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD   = 2'b00,
        STEP_UP     = 2'b01,
        STEP_DOWN   = 2'b10,
        STEP_OFFSET = 2'b11
    } step_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRSV = 2'b11
    } size_e;

    localparam int unsigned AREA_CODE_W = 5;

endpackage

// File: rtl/dma_step_delta.sv
module dma_step_delta
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned OFW       = 24,
    parameter bit          OFFSET_EN = 1'b1
) (
    input  logic [1:0]     step_mode,
    input  logic [1:0]     size_code,
    input  logic [OFW-1:0] offset,
    output logic [AW-1:0]  delta
);

    logic [AW-1:0] bytes_w;
    logic [AW-1:0] offset_ext;

    always_comb begin
        unique case (size_e'(size_code))
            SZ_BYTE: bytes_w = AW'(1);
            SZ_HALF: bytes_w = AW'(2);
            default: bytes_w = AW'(4);
        endcase
    end

    generate
        if (!OFFSET_EN) begin : g_no_offset
            assign offset_ext = '0;
        end else if (OFW < AW) begin : g_sext
            assign offset_ext = {{(AW-OFW){offset[OFW-1]}}, offset};
        end else begin : g_trunc
            assign offset_ext = offset[AW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (step_mode_e'(step_mode))
            STEP_UP:     delta = bytes_w;
            STEP_DOWN:   delta = (~bytes_w) + AW'(1);
            STEP_OFFSET: delta = offset_ext;
            default:     delta = '0;
        endcase
    end

endmodule

// File: rtl/dma_area_wrap.sv
module dma_area_wrap
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0]          addr_cur,
    input  logic [AW-1:0]          addr_raw,
    input  logic [AREA_CODE_W-1:0] area_code,
    output logic [AW-1:0]          addr_next,
    output logic                   wrapped
);

    logic [AW-1:0] low_mask;
    logic          win_on;

    always_comb begin
        win_on    = (area_code != '0);
        low_mask  = win_on ? ~({AW{1'b1}} << area_code) : {AW{1'b1}};
        addr_next = (addr_cur & ~low_mask) | (addr_raw & low_mask);
        wrapped   = win_on && (((addr_cur ^ addr_raw) & ~low_mask) != '0);
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW        = 32,
    parameter int unsigned OFW       = 24,
    parameter bit          OFFSET_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [AW-1:0]          start_addr,
    input  logic [1:0]             step_mode,
    input  logic [1:0]             size_code,
    input  logic [OFW-1:0]         offset,
    input  logic [AREA_CODE_W-1:0] area_code,
    input  logic                   ovf_en,
    input  logic                   block_mode,
    input  logic                   block_last,
    input  logic                   advance,
    input  logic                   ovf_ack,
    output logic [AW-1:0]          addr,
    output logic                   ovf_stop
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          stop;
        logic          pend;
    } step_state_t;

    step_state_t   st_d, st_q;
    logic [AW-1:0] delta_w;
    logic [AW-1:0] raw_w;
    logic [AW-1:0] next_w;
    logic          wrap_w;
    logic          hit_w;

    dma_step_delta #(
        .AW        (AW),
        .OFW       (OFW),
        .OFFSET_EN (OFFSET_EN)
    ) u_delta (
        .step_mode (step_mode),
        .size_code (size_code),
        .offset    (offset),
        .delta     (delta_w)
    );

    assign raw_w = st_q.addr + delta_w;

    dma_area_wrap #(
        .AW (AW)
    ) u_wrap (
        .addr_cur  (st_q.addr),
        .addr_raw  (raw_w),
        .area_code (area_code),
        .addr_next (next_w),
        .wrapped   (wrap_w)
    );

    assign hit_w = wrap_w && ovf_en;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.addr = start_addr;
            st_d.stop = 1'b0;
            st_d.pend = 1'b0;
        end else begin
            if (ovf_ack) begin
                st_d.stop = 1'b0;
            end
            if (advance) begin
                st_d.addr = next_w;
                if (block_mode) begin
                    if ((st_q.pend || hit_w) && block_last) begin
                        st_d.stop = 1'b1;
                        st_d.pend = 1'b0;
                    end else if (hit_w) begin
                        st_d.pend = 1'b1;
                    end
                end else if (hit_w) begin
                    st_d.stop = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr     = st_q.addr;
    assign ovf_stop = st_q.stop;

endmodule

// File: rtl/dma_addr_step_chk.sv
module dma_addr_step_chk
    import dma_addr_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load,
    input logic [AW-1:0]          start_addr,
    input logic [1:0]             step_mode,
    input logic [AREA_CODE_W-1:0] area_code,
    input logic                   ovf_en,
    input logic                   advance,
    input logic [AW-1:0]          addr,
    input logic                   ovf_stop
);

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past(start_addr)); // R2

    AST_LOAD_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ovf_stop); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> $stable(addr)); // R3

    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && advance && step_mode == 2'b00) |=> $stable(addr)); // R3

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && advance && area_code != '0) |=>
            (((addr ^ $past(addr)) >> $past(area_code)) == '0)); // R8

    AST_STOP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_stop) |-> ($past(advance) && $past(ovf_en))); // R10

endmodule

bind dma_addr_step dma_addr_step_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .start_addr (start_addr),
    .step_mode  (step_mode),
    .area_code  (area_code),
    .ovf_en     (ovf_en),
    .advance    (advance),
    .addr       (addr),
    .ovf_stop   (ovf_stop)
);

// File: tb/test_dma_addr_step.sv
module test_dma_addr_step;

    localparam int unsigned AW  = 32;
    localparam int unsigned OFW = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           load = 1'b0;
    logic [AW-1:0]  start_addr = '0;
    logic [1:0]     step_mode = 2'b00;
    logic [1:0]     size_code = 2'b00;
    logic [OFW-1:0] offset = '0;
    logic [4:0]     area_code = '0;
    logic           ovf_en = 1'b0;
    logic           block_mode = 1'b0;
    logic           block_last = 1'b0;
    logic           advance = 1'b0;
    logic           ovf_ack = 1'b0;
    logic [AW-1:0]  addr, addr_no;
    logic           ovf_stop, stop_no;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma_addr_step #(.AW(AW), .OFW(OFW), .OFFSET_EN(1'b1)) i_dma_addr_step (
        .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
        .step_mode(step_mode), .size_code(size_code), .offset(offset),
        .area_code(area_code), .ovf_en(ovf_en), .block_mode(block_mode),
        .block_last(block_last), .advance(advance), .ovf_ack(ovf_ack),
        .addr(addr), .ovf_stop(ovf_stop)
    );

    dma_addr_step #(.AW(AW), .OFW(OFW), .OFFSET_EN(1'b0)) i_dma_addr_step_nooff (
        .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
        .step_mode(step_mode), .size_code(size_code), .offset(offset),
        .area_code(area_code), .ovf_en(ovf_en), .block_mode(block_mode),
        .block_last(block_last), .advance(advance), .ovf_ack(ovf_ack),
        .addr(addr_no), .ovf_stop(stop_no)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a);
        @(negedge clk); start_addr = a; load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic do_adv(input logic last);
        @(negedge clk); advance = 1'b1; block_last = last;
        @(negedge clk); advance = 1'b0; block_last = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk); ovf_ack = 1'b1;
        @(negedge clk); ovf_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 addr", addr, '0);
        chk("R1 stop", AW'(ovf_stop), '0);
    endtask

    task automatic t_load_hold();
        do_load(32'h0000_1000);
        chk("R2 load", addr, 32'h0000_1000);
        step_mode = 2'b00;
        do_adv(1'b0);
        chk("R3 hold advance", addr, 32'h0000_1000);
        repeat (3) @(negedge clk);
        chk("R3 idle", addr, 32'h0000_1000);
    endtask

    task automatic t_up_down();
        step_mode = 2'b01;
        size_code = 2'b00; do_adv(1'b0); chk("R4 byte", addr, 32'h0000_1001);
        size_code = 2'b01; do_adv(1'b0); chk("R4 half", addr, 32'h0000_1003);
        size_code = 2'b10; do_adv(1'b0); chk("R4 word", addr, 32'h0000_1007);
        size_code = 2'b11; do_adv(1'b0); chk("R4 code11", addr, 32'h0000_100B);
        step_mode = 2'b10;
        size_code = 2'b10; do_adv(1'b0); chk("R5 word", addr, 32'h0000_1007);
        size_code = 2'b00; do_adv(1'b0); chk("R5 byte", addr, 32'h0000_1006);
    endtask

    task automatic t_offset();
        do_load(32'h0000_2000);
        step_mode = 2'b11;
        offset = 24'h000010; do_adv(1'b0);
        chk("R6 positive", addr, 32'h0000_2010);
        chk("R7 no offset", addr_no, 32'h0000_2000);
        offset = 24'hFFFFE0; do_adv(1'b0);
        chk("R6 negative", addr, 32'h0000_1FF0);
        chk("R7 no offset", addr_no, 32'h0000_2000);
        do_load(32'h0100_0008);
        offset = 24'hFFFFF0; do_adv(1'b0);
        chk("R6 sign extend", addr, 32'h00FF_FFF8);
    endtask

    task automatic t_window();
        step_mode = 2'b01; size_code = 2'b00; area_code = 5'd3; ovf_en = 1'b0;
        do_load(32'h0000_1006);
        do_adv(1'b0); chk("R8 inside", addr, 32'h0000_1007);
        do_adv(1'b0); chk("R8 wrap up", addr, 32'h0000_1000);
        chk("R10 no stop", AW'(ovf_stop), '0);
        step_mode = 2'b10;
        do_adv(1'b0); chk("R8 wrap down", addr, 32'h0000_1007);
        area_code = 5'd0; step_mode = 2'b01;
        do_adv(1'b0); chk("R8 code0 carry", addr, 32'h0000_1008);
    endtask

    task automatic t_stop();
        step_mode = 2'b01; size_code = 2'b00; area_code = 5'd3; ovf_en = 1'b1;
        do_load(32'h0000_1007);
        do_adv(1'b0);
        chk("R9 wrapped addr", addr, 32'h0000_1000);
        chk("R9 stop", AW'(ovf_stop), 1);
        do_adv(1'b0);
        chk("R9 keeps stepping", addr, 32'h0000_1001);
        chk("R9 stop held", AW'(ovf_stop), 1);
        do_ack();
        chk("R12 ack", AW'(ovf_stop), '0);
        do_load(32'h0000_1007);
        @(negedge clk); advance = 1'b1; ovf_ack = 1'b1;
        @(negedge clk); advance = 1'b0; ovf_ack = 1'b0;
        chk("R12 set wins", AW'(ovf_stop), 1);
        do_load(32'h0000_1003);
        chk("R2 load clears", AW'(ovf_stop), '0);
    endtask

    task automatic t_block();
        step_mode = 2'b01; size_code = 2'b01; area_code = 5'd3; ovf_en = 1'b1;
        block_mode = 1'b1;
        do_load(32'h0000_1006);
        do_adv(1'b0);
        chk("R11 wrap addr", addr, 32'h0000_1000);
        chk("R11 deferred", AW'(ovf_stop), '0);
        do_adv(1'b0);
        chk("R11 still deferred", AW'(ovf_stop), '0);
        do_adv(1'b1);
        chk("R11 block end addr", addr, 32'h0000_1004);
        chk("R11 stop at end", AW'(ovf_stop), 1);
        do_load(32'h0000_1006);
        do_adv(1'b1);
        chk("R11 wrap on last", AW'(ovf_stop), 1);
        block_mode = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_load_hold();
                t_up_down();
                t_offset();
                t_window();
                t_stop();
                t_block();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule